// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the timing and strobe generator for a small single-accumulator machine with 16-bit instruction words. A step counter advances once per clock while the machine runs and is decoded into one-hot timing pulses. The three opcode bits of the instruction word are decoded into eight one-hot opcode lines, and the top bit of the word, which selects indirect addressing, is captured into a mode flag at decode time. Every output is a fixed product of one timing pulse and one opcode line, so each instruction follows a fixed schedule. The schedule covers fetch, decode, one extra memory read for an indirect address, and the seven memory-reference operations. Register-reference and I/O words are only recognised, and they end at the fourth step.

The surrounding datapath owns the registers, the memory and the shared bus. It shows the instruction register on `irWord` and a data-register-is-zero flag on `drZero`. In return it receives a bus source code, load, increment and clear strobes for each register, memory read and write enables, and an ALU function code. A pulse on `start` sets the machine running. A register-reference word with bit 0 set halts it with the counter parked at step 0.

Top module: `hw_seq_ctrl`

## Requirements
- R1: While `rstN` is low, and after it is released, `seqCount` is 0, `running` is 0 and every strobe output is 0.
- R2: While `running` is 0, every strobe is 0 and `seqCount` stays 0. A high `start` in that state sets `running` at the next edge. While running, `seqCount` rises by one per cycle unless `seqEnd` was high, and the first cycle of every instruction has `seqCount` 0.
- R3: Step 0 drives `busSel`=2 (program counter) with `arLd`, and no other strobe.
- R4: Step 1 drives `memRead`, `busSel`=7 (memory), `irLd` and `pcInr`.
- R5: Step 2 drives `busSel`=5 (instruction register) with `arLd`. In the same step, `irWord[15]` is captured as the indirect flag.
- R6: At step 3, for opcodes 0 to 6 (`irWord[14:12]`): with the captured flag at 1, the block drives `memRead`, `busSel`=7 and `arLd`. With the flag at 0, it drives no strobe.
- R7: Opcodes 0 (AND), 1 (ADD) and 2 (load) drive `memRead`, `busSel`=7 and `drLd` at step 4. At step 5 they drive `acLd` and `seqEnd`, with `aluOp` equal to 1, 2 or 3 respectively. `aluOp` is 0 at all other times.
- R8: Opcode 3 (store) drives `busSel`=4 (accumulator), `memWrite` and `seqEnd` at step 4. Opcode 4 (jump) drives `busSel`=1 (address register), `pcLd` and `seqEnd` at step 4.
- R9: Opcode 5 (call) drives `busSel`=2, `memWrite` and `arInr` at step 4. At step 5 it drives `busSel`=1, `pcLd` and `seqEnd`.
- R10: Opcode 6 (increment and skip) drives a memory read into DR at step 4 and `drInr` at step 5. At step 6 it drives `busSel`=3 (data register), `memWrite` and `seqEnd`, and drives `pcInr` exactly when `drZero` is 1.
- R11: Opcode 7 drives only `seqEnd` at step 3, whatever the indirect bit, and the next instruction starts at step 0.
- R12: Opcode 7 with `irWord[15]`=0 and `irWord[0]`=1 is a halt. `running` is 0 from the next cycle, with `seqCount` 0 and no strobe, until `start` is pulsed again.
- R13: `memRead` and `memWrite` are never high together, and `seqCount` is 0 in the cycle after any `seqEnd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sets the run flag while halted |
| irWord | input | 16 | Current instruction register contents |
| drZero | input | 1 | Data register equals zero |
| busSel | output | 3 | Bus source code (1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 7 memory) |
| aluOp | output | 2 | ALU function (0 none, 1 AND, 2 add, 3 pass DR) |
| arLd | output | 1 | Load address register from bus |
| arInr | output | 1 | Increment address register |
| pcLd | output | 1 | Load program counter from bus |
| pcInr | output | 1 | Increment program counter |
| drLd | output | 1 | Load data register from bus |
| drInr | output | 1 | Increment data register |
| acLd | output | 1 | Load accumulator from ALU |
| irLd | output | 1 | Load instruction register from bus |
| memRead | output | 1 | Memory read enable |
| memWrite | output | 1 | Memory write enable |
| seqEnd | output | 1 | Last step of the instruction; clears the counter |
| seqCount | output | 4 | Current step number |
| running | output | 1 | Run flag |

## Verification
The strobes are combinational in the current step, so they are due in the same cycle as the `seqCount` value they belong to. The bench drives `irWord` and `drZero` just after a falling edge and samples one time unit later, well before the next rising edge. Counter effects (`seqEnd` clearing the count, `start` and halt changing `running`) appear one rising edge later, at the next falling-edge sample. The indirect flag is captured at the edge that ends step 2 and shows up in the step-3 strobes. The sweep runs every opcode with both indirect bits and both `drZero` values, and compares every step with a schedule the bench computes itself.

// File: rtl/hw_seq_pkg.sv
`timescale 1ns/1ps
package hw_seq_pkg;

  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_AR   = 3'd1,
    BUS_PC   = 3'd2,
    BUS_DR   = 3'd3,
    BUS_AC   = 3'd4,
    BUS_IR   = 3'd5,
    BUS_TR   = 3'd6,
    BUS_MEM  = 3'd7
  } bus_src_e;

  typedef enum logic [1:0] {
    ALU_NONE = 2'd0,
    ALU_AND  = 2'd1,
    ALU_ADD  = 2'd2,
    ALU_PASS = 2'd3
  } alu_op_e;

  typedef struct packed {
    bus_src_e busSel;
    alu_op_e  aluOp;
    logic     arLd;
    logic     arInr;
    logic     pcLd;
    logic     pcInr;
    logic     drLd;
    logic     drInr;
    logic     acLd;
    logic     irLd;
    logic     memRead;
    logic     memWrite;
    logic     seqEnd;
    logic     iCap;
    logic     haltReq;
  } ctrl_strobe_t;

endpackage

// File: rtl/hw_seq_timing.sv
`timescale 1ns/1ps
module hw_seq_timing #(
  parameter int SC_W  = 4,
  parameter int OPC_W = 3,
  localparam int TP_N = 1 << SC_W,
  localparam int D_N  = 1 << OPC_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [OPC_W-1:0]          opField,
  input  logic                      modeBit,
  input  hw_seq_pkg::ctrl_strobe_t  strb,
  output logic [TP_N-1:0]           tPulse,
  output logic [D_N-1:0]            dLine,
  output logic                      iFlag,
  output logic [SC_W-1:0]           seqCount,
  output logic                      running
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCount <= '0;
      running  <= 1'b0;
      iFlag    <= 1'b0;
    end else begin
      if (!running) begin
        seqCount <= '0;
        if (start) running <= 1'b1;
      end else begin
        if (strb.seqEnd) seqCount <= '0;
        else             seqCount <= seqCount + 1'b1;
        if (strb.haltReq) running <= 1'b0;
      end
      if (strb.iCap) iFlag <= modeBit;
    end
  end

  for (genvar i = 0; i < TP_N; i++) begin : g_tdec
    assign tPulse[i] = running && (seqCount == SC_W'(i));
  end

  for (genvar j = 0; j < D_N; j++) begin : g_ddec
    assign dLine[j] = (opField == OPC_W'(j));
  end

endmodule

// File: rtl/hw_seq_decode.sv
`timescale 1ns/1ps
module hw_seq_decode #(
  parameter int SC_W  = 4,
  parameter int OPC_W = 3,
  localparam int TP_N = 1 << SC_W,
  localparam int D_N  = 1 << OPC_W
) (
  input  logic [TP_N-1:0]          tPulse,
  input  logic [D_N-1:0]           dLine,
  input  logic                     iFlag,
  input  logic                     haltBit,
  input  logic                     drZero,
  output hw_seq_pkg::ctrl_strobe_t strb
);
  import hw_seq_pkg::*;

  logic unusedHighPulses;
  assign unusedHighPulses = |tPulse[TP_N-1:7];

  logic memRef;
  assign memRef = !dLine[7];

  always_comb begin
    strb = '0;
    // fetch: AR <- PC
    if (tPulse[0]) begin
      strb.busSel = BUS_PC;
      strb.arLd   = 1'b1;
    end
    // fetch: IR <- M[AR], PC + 1
    if (tPulse[1]) begin
      strb.busSel  = BUS_MEM;
      strb.memRead = 1'b1;
      strb.irLd    = 1'b1;
      strb.pcInr   = 1'b1;
    end
    // decode: AR <- address field, capture mode bit
    if (tPulse[2]) begin
      strb.busSel = BUS_IR;
      strb.arLd   = 1'b1;
      strb.iCap   = 1'b1;
    end
    // indirect resolution
    if (tPulse[3] && memRef && iFlag) begin
      strb.busSel  = BUS_MEM;
      strb.memRead = 1'b1;
      strb.arLd    = 1'b1;
    end
    // register-reference or I/O: end here
    if (tPulse[3] && dLine[7]) begin
      strb.seqEnd  = 1'b1;
      strb.haltReq = !iFlag && haltBit;
    end
    // operand read for AND, ADD, load, ISZ
    if (tPulse[4] && (dLine[0] || dLine[1] || dLine[2] || dLine[6])) begin
      strb.busSel  = BUS_MEM;
      strb.memRead = 1'b1;
      strb.drLd    = 1'b1;
    end
    if (tPulse[5] && (dLine[0] || dLine[1] || dLine[2])) begin
      strb.acLd   = 1'b1;
      strb.seqEnd = 1'b1;
      strb.aluOp  = dLine[0] ? ALU_AND : (dLine[1] ? ALU_ADD : ALU_PASS);
    end
    // store
    if (tPulse[4] && dLine[3]) begin
      strb.busSel   = BUS_AC;
      strb.memWrite = 1'b1;
      strb.seqEnd   = 1'b1;
    end
    // jump
    if (tPulse[4] && dLine[4]) begin
      strb.busSel = BUS_AR;
      strb.pcLd   = 1'b1;
      strb.seqEnd = 1'b1;
    end
    // call: save return, then jump past it
    if (tPulse[4] && dLine[5]) begin
      strb.busSel   = BUS_PC;
      strb.memWrite = 1'b1;
      strb.arInr    = 1'b1;
    end
    if (tPulse[5] && dLine[5]) begin
      strb.busSel = BUS_AR;
      strb.pcLd   = 1'b1;
      strb.seqEnd = 1'b1;
    end
    // increment and skip if zero
    if (tPulse[5] && dLine[6]) begin
      strb.drInr = 1'b1;
    end
    if (tPulse[6] && dLine[6]) begin
      strb.busSel   = BUS_DR;
      strb.memWrite = 1'b1;
      strb.pcInr    = drZero;
      strb.seqEnd   = 1'b1;
    end
  end

endmodule

// File: rtl/hw_seq_ctrl.sv
`timescale 1ns/1ps
module hw_seq_ctrl #(
  parameter int IR_W  = 16,
  parameter int SC_W  = 4,
  parameter int OPC_W = 3,
  localparam int TP_N    = 1 << SC_W,
  localparam int D_N     = 1 << OPC_W,
  localparam int OPC_LSB = IR_W - 1 - OPC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [IR_W-1:0] irWord,
  input  logic            drZero,
  output logic [2:0]      busSel,
  output logic [1:0]      aluOp,
  output logic            arLd,
  output logic            arInr,
  output logic            pcLd,
  output logic            pcInr,
  output logic            drLd,
  output logic            drInr,
  output logic            acLd,
  output logic            irLd,
  output logic            memRead,
  output logic            memWrite,
  output logic            seqEnd,
  output logic [SC_W-1:0] seqCount,
  output logic            running
);
  import hw_seq_pkg::*;

  ctrl_strobe_t    strb;
  logic [TP_N-1:0] tPulse;
  logic [D_N-1:0]  dLine;
  logic            iFlag;

  logic unusedIrBits;
  assign unusedIrBits = ^irWord[OPC_LSB-1:1];

  hw_seq_timing #(.SC_W(SC_W), .OPC_W(OPC_W)) u_timing (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opField  (irWord[IR_W-2:OPC_LSB]),
    .modeBit  (irWord[IR_W-1]),
    .strb     (strb),
    .tPulse   (tPulse),
    .dLine    (dLine),
    .iFlag    (iFlag),
    .seqCount (seqCount),
    .running  (running)
  );

  hw_seq_decode #(.SC_W(SC_W), .OPC_W(OPC_W)) u_decode (
    .tPulse  (tPulse),
    .dLine   (dLine),
    .iFlag   (iFlag),
    .haltBit (irWord[0]),
    .drZero  (drZero),
    .strb    (strb)
  );

  assign busSel   = strb.busSel;
  assign aluOp    = strb.aluOp;
  assign arLd     = strb.arLd;
  assign arInr    = strb.arInr;
  assign pcLd     = strb.pcLd;
  assign pcInr    = strb.pcInr;
  assign drLd     = strb.drLd;
  assign drInr    = strb.drInr;
  assign acLd     = strb.acLd;
  assign irLd     = strb.irLd;
  assign memRead  = strb.memRead;
  assign memWrite = strb.memWrite;
  assign seqEnd   = strb.seqEnd;

endmodule

// File: rtl/hw_seq_ctrl_chk.sv
`timescale 1ns/1ps
module hw_seq_ctrl_chk #(
  parameter int SC_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      busSel,
  input logic            arLd,
  input logic            pcLd,
  input logic            pcInr,
  input logic            drLd,
  input logic            acLd,
  input logic            irLd,
  input logic            memRead,
  input logic            memWrite,
  input logic            seqEnd,
  input logic [SC_W-1:0] seqCount,
  input logic            running
);

  // R13
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  // R13
  seq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqEnd |=> (seqCount == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !seqEnd) |=> (seqCount == SC_W'($past(seqCount) + 1'b1)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !(memRead || memWrite || arLd || pcLd || pcInr || irLd ||
                   drLd || acLd || seqEnd));

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && seqCount == '0) |-> (arLd && busSel == 3'd2));

  // R6
  mem_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> (busSel == 3'd7));

  // R12
  halt_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> (seqCount == '0));

endmodule

bind hw_seq_ctrl hw_seq_ctrl_chk #(.SC_W(SC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .arLd     (arLd),
  .pcLd     (pcLd),
  .pcInr    (pcInr),
  .drLd     (drLd),
  .acLd     (acLd),
  .irLd     (irLd),
  .memRead  (memRead),
  .memWrite (memWrite),
  .seqEnd   (seqEnd),
  .seqCount (seqCount),
  .running  (running)
);

// File: tb/hw_seq_ctrl_bench.sv
`timescale 1ns/1ps
module hw_seq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] irWord = '0;
  logic        drZero = 1'b0;
  logic [2:0]  busSel;
  logic [1:0]  aluOp;
  logic        arLd, arInr, pcLd, pcInr, drLd, drInr, acLd, irLd;
  logic        memRead, memWrite, seqEnd;
  logic [3:0]  seqCount;
  logic        running;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hw_seq_ctrl u_hw_seq_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .irWord(irWord), .drZero(drZero),
    .busSel(busSel), .aluOp(aluOp), .arLd(arLd), .arInr(arInr), .pcLd(pcLd),
    .pcInr(pcInr), .drLd(drLd), .drInr(drInr), .acLd(acLd), .irLd(irLd),
    .memRead(memRead), .memWrite(memWrite), .seqEnd(seqEnd),
    .seqCount(seqCount), .running(running)
  );

  // {busSel, aluOp, arLd, arInr, pcLd, pcInr, drLd, drInr, acLd, irLd, memRead, memWrite, seqEnd}
  function automatic logic [15:0] observed();
    return {busSel, aluOp, arLd, arInr, pcLd, pcInr, drLd, drInr, acLd, irLd,
            memRead, memWrite, seqEnd};
  endfunction

  function automatic logic [15:0] schedule(int t, logic [15:0] ir, logic dz);
    logic [2:0] bs = 3'd0;
    logic [1:0] al = 2'd0;
    logic aL = 0, aI = 0, pL = 0, pI = 0, dL = 0, dI = 0, cL = 0, iL = 0;
    logic mR = 0, mW = 0, en = 0;
    int op = int'(ir[14:12]);
    logic ind = ir[15];
    case (t)
      0: begin bs = 3'd2; aL = 1; end
      1: begin bs = 3'd7; mR = 1; iL = 1; pI = 1; end
      2: begin bs = 3'd5; aL = 1; end
      3: begin
        if (op == 7) en = 1;
        else if (ind) begin bs = 3'd7; mR = 1; aL = 1; end
      end
      4: begin
        if (op <= 2 || op == 6) begin bs = 3'd7; mR = 1; dL = 1; end
        else if (op == 3) begin bs = 3'd4; mW = 1; en = 1; end
        else if (op == 4) begin bs = 3'd1; pL = 1; en = 1; end
        else if (op == 5) begin bs = 3'd2; mW = 1; aI = 1; end
      end
      5: begin
        if (op <= 2) begin al = 2'(op + 1); cL = 1; en = 1; end
        else if (op == 5) begin bs = 3'd1; pL = 1; en = 1; end
        else if (op == 6) dI = 1;
      end
      6: if (op == 6) begin bs = 3'd3; mW = 1; pI = dz; en = 1; end
      default: ;
    endcase
    return {bs, al, aL, aI, pL, pI, dL, dI, cL, iL, mR, mW, en};
  endfunction

  function automatic string reqTag(int t, logic [15:0] ir);
    int op = int'(ir[14:12]);
    if (t == 0) return "R3";
    if (t == 1) return "R4";
    if (t == 2) return "R5";
    if (op == 7) return "R11";
    if (t == 3) return "R6";
    if (op <= 2) return "R7";
    if (op <= 4) return "R8";
    if (op == 5) return "R9";
    return "R10";
  endfunction

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic runInstr(logic [15:0] ir, logic dz);
    for (int t = 0; t < 8; t++) begin
      logic [15:0] want;
      @(negedge clk);
      irWord = ir;
      drZero = dz;
      #1;
      want = schedule(t, ir, dz);
      // R2: step count and run flag during an instruction
      check16("R2", {11'd0, running, seqCount}, {11'd0, 1'b1, 4'(t)});
      check16(reqTag(t, ir), observed(), want);
      if (want[0]) break;
    end
  endtask

  initial begin
    #1;
    // R1: state held in reset
    check16("R1", {11'd0, running, seqCount}, 16'd0);
    check16("R1", observed(), 16'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    irWord = 16'h1234;
    repeat (3) @(negedge clk);
    #1;
    // R1 after release, R2 idle without start
    check16("R1", {11'd0, running, seqCount}, 16'd0);
    check16("R2", observed(), 16'd0);

    pulseStart();
    for (int op = 0; op < 8; op++) begin
      for (int ind = 0; ind < 2; ind++) begin
        for (int dz = 0; dz < 2; dz++) begin
          logic [10:0] addr = 11'h152 ^ 11'(op * 37 + dz * 5);
          runInstr({ind[0], op[2:0], addr, 1'b0}, dz[0]);
        end
      end
    end

    // R12: halt word ends at step 3, then the machine stays parked
    runInstr(16'h7001, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      irWord = 16'h0AB0;
      #1;
      check16("R12", {11'd0, running, seqCount}, 16'd0);
      check16("R12", observed(), 16'd0);
    end
    // R11: I/O word with bit 0 set does not halt
    pulseStart();
    runInstr(16'hF001, 1'b1);
    runInstr(16'h2456, 1'b0);
    runInstr(16'hE7F0, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule